// File: doc/BRIEF.md
# MIDI Note Message Decoder

This block sits behind a serial MIDI byte receiver. It takes each received byte together with its one-cycle valid strobe, sorts the byte into a command (status) byte or a payload (data) byte by its top bit, and keeps track of where the current message stands. A message is one status byte followed by two data bytes: the key number first, then the strike velocity.

When a Note On message (any channel) completes, the decoder loads the 7-bit key number into a register that drives seven indicator lines, and loads the velocity into a second register. Both registers keep their value until the next complete Note On message. A one-cycle completion pulse marks every finished Note On or Note Off message. Other commands, stray data bytes and partial messages cut short by a new status byte leave the outputs untouched.

Top module: `midi_note_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, note_led, velocity and msg_done are all zero.
- R2: A byte whose bit 7 is 1 is a status byte, and a byte whose bit 7 is 0 is a data byte. A status byte with upper nibble 0x9 (Note On, any lower-nibble channel), followed by two data bytes, sets note_led to bits 6:0 of the first data byte and velocity to bits 6:0 of the second. Both registers take these values in the cycle after the clock edge that accepts the second data byte.
- R3: msg_done is high for exactly one cycle, the cycle after the edge that accepts the second data byte of a Note On or a Note Off (upper nibble 0x8) message. At all other times it is low.
- R4: A complete Note Off message pulses msg_done but leaves note_led and velocity unchanged.
- R5: A status byte with an upper nibble other than 0x8 or 0x9, and the data bytes that follow it, produce no msg_done pulse and no output change.
- R6: Data bytes received after reset or after a completed message, with no new status byte before them, are ignored: no pulse and no output change.
- R7: A status byte that arrives part-way through a message drops the partial message and starts a new one. The next two data bytes belong to the new message.
- R8: When rx_valid is low, rx_byte has no effect on the decoder.
- R9: note_led and velocity change only in a cycle in which msg_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | One-cycle strobe marking rx_byte as a new byte |
| note_led | output | 7 | Key number of the last complete Note On, drives the indicator lines |
| velocity | output | 7 | Velocity of the last complete Note On |
| msg_done | output | 1 | One-cycle pulse after a Note On or Note Off message completes |

## Verification
A wrong byte-position state shows at the ports within one byte. msg_done pulses after the wrong byte, or fails to pulse, and note_led then shows the velocity, a stale key or nothing new. A lost Note On/Off flag shows up as a register update after a Note Off, or as a missing update after a Note On, in the cycle after the closing byte. Because the registers hold their value, a wrong update stays visible at the ports until the next Note On message completes.

// File: rtl/midi_dec_pkg.sv
package midi_dec_pkg;
  typedef enum logic [1:0] {
    POS_IDLE     = 2'd0,
    POS_WANT_KEY = 2'd1,
    POS_WANT_VEL = 2'd2
  } msg_pos_t;
endpackage

// File: rtl/midi_byte_class.sv
module midi_byte_class #(
  parameter logic [3:0] CMD_ON  = 4'h9,
  parameter logic [3:0] CMD_OFF = 4'h8
) (
  input  logic [3:0] hi_nib,
  output logic       is_status,
  output logic       is_on,
  output logic       is_off
);
  always_comb begin
    is_status = hi_nib[3];
    is_on     = (hi_nib == CMD_ON);
    is_off    = (hi_nib == CMD_OFF);
  end
endmodule

// File: rtl/midi_msg_tracker.sv
module midi_msg_tracker
  import midi_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic is_status,
  input  logic is_on,
  input  logic is_off,
  output logic take_key,
  output logic take_vel,
  output logic fin_on
);
  msg_pos_t pos_q, pos_d;
  logic     on_q, on_d;
  logic     data_seen;

  always_comb begin
    data_seen = valid_i & ~is_status;
    take_key  = data_seen & (pos_q == POS_WANT_KEY);
    take_vel  = data_seen & (pos_q == POS_WANT_VEL);
    fin_on    = take_vel & on_q;
    pos_d     = pos_q;
    on_d      = on_q;
    if (valid_i && is_status) begin
      pos_d = (is_on || is_off) ? POS_WANT_KEY : POS_IDLE;
      on_d  = is_on;
    end else if (take_key) begin
      pos_d = POS_WANT_VEL;
    end else if (take_vel) begin
      pos_d = POS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= POS_IDLE;
      on_q  <= 1'b0;
    end else begin
      pos_q <= pos_d;
      on_q  <= on_d;
    end
  end
endmodule

// File: rtl/midi_note_regs.sv
module midi_note_regs #(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_key,
  input  logic              take_vel,
  input  logic              fin_on,
  output logic [DATA_W-1:0] note_o,
  output logic [DATA_W-1:0] vel_o,
  output logic              done_o
);
  logic [DATA_W-1:0] key_q, key_d;
  logic [DATA_W-1:0] note_q, note_d;
  logic [DATA_W-1:0] vel_q, vel_d;
  logic              done_q;

  always_comb begin
    key_d  = take_key ? data_i : key_q;
    note_d = fin_on   ? key_q  : note_q;
    vel_d  = fin_on   ? data_i : vel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      note_q <= '0;
      vel_q  <= '0;
      done_q <= 1'b0;
    end else begin
      key_q  <= key_d;
      note_q <= note_d;
      vel_q  <= vel_d;
      done_q <= take_vel;
    end
  end

  assign note_o = note_q;
  assign vel_o  = vel_q;
  assign done_o = done_q;
endmodule

// File: rtl/midi_note_decoder.sv
module midi_note_decoder #(
  parameter int         DATA_W  = 7,
  parameter logic [3:0] CMD_ON  = 4'h9,
  parameter logic [3:0] CMD_OFF = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W:0]   rx_byte,
  input  logic              rx_valid,
  output logic [DATA_W-1:0] note_led,
  output logic [DATA_W-1:0] velocity,
  output logic              msg_done
);
  localparam int BYTE_W = DATA_W + 1;

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       is_status, is_on, is_off;
  logic       take_key, take_vel, fin_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  midi_byte_class #(.CMD_ON(CMD_ON), .CMD_OFF(CMD_OFF)) u_class (
    .hi_nib    (rx_byte[BYTE_W-1 -: 4]),
    .is_status (is_status),
    .is_on     (is_on),
    .is_off    (is_off)
  );

  midi_msg_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .valid_i   (rx_valid),
    .is_status (is_status),
    .is_on     (is_on),
    .is_off    (is_off),
    .take_key  (take_key),
    .take_vel  (take_vel),
    .fin_on    (fin_on)
  );

  midi_note_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .data_i   (rx_byte[DATA_W-1:0]),
    .take_key (take_key),
    .take_vel (take_vel),
    .fin_on   (fin_on),
    .note_o   (note_led),
    .vel_o    (velocity),
    .done_o   (msg_done)
  );
endmodule

// File: rtl/midi_note_decoder_chk.sv
module midi_note_decoder_chk #(
  parameter int DATA_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_msb,
  input logic [DATA_W-1:0] note_led,
  input logic [DATA_W-1:0] velocity,
  input logic              msg_done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !msg_done); // R3
  AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> $past(rx_valid && !rx_msb)); // R3
  AST_STATUS_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_msb) |=> !msg_done); // R7
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !msg_done); // R8
  AST_NOTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(note_led) |-> msg_done); // R9
  AST_VEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(velocity) |-> msg_done); // R9
endmodule

bind midi_note_decoder midi_note_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_valid (rx_valid),
  .rx_msb   (rx_byte[DATA_W]),
  .note_led (note_led),
  .velocity (velocity),
  .msg_done (msg_done)
);

// File: tb/test_midi_note_decoder.sv
`timescale 1ns/1ps
module test_midi_note_decoder;
  logic       clk;
  logic       rst_n;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic [6:0] note_led;
  logic [6:0] velocity;
  logic       msg_done;
  int total = 0;
  int bad   = 0;

  midi_note_decoder i_midi_note_decoder (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .note_led(note_led), .velocity(velocity), .msg_done(msg_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drives one byte for one cycle; on return, outputs reflect that byte.
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 note", note_led, 0);
    check("R1 vel", velocity, 0);
    check("R1 done", msg_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 note after release", note_led, 0);
    check("R1 done after release", msg_done, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_note_on;
    send(8'h93);
    send(8'h3C);
    check("R3 no done after key", msg_done, 0);
    send(8'h64);
    check("R2 note", note_led, 8'h3C);
    check("R2 vel", velocity, 8'h64);
    check("R3 done pulse", msg_done, 1);
    @(negedge clk);
    check("R3 done drops", msg_done, 0);
  endtask

  task automatic t_note_off;
    send(8'h85);
    send(8'h45);
    send(8'h10);
    check("R3 done on note off", msg_done, 1);
    check("R4 note kept", note_led, 8'h3C);
    check("R4 vel kept", velocity, 8'h64);
  endtask

  task automatic t_other_cmd;
    send(8'hB0);
    send(8'h07);
    check("R5 no done", msg_done, 0);
    send(8'h7F);
    check("R5 no done end", msg_done, 0);
    check("R5 note kept", note_led, 8'h3C);
  endtask

  task automatic t_orphan;
    send(8'h9A); send(8'h01); send(8'h02);
    check("R6 setup note", note_led, 8'h01);
    send(8'h11);
    send(8'h22);
    check("R6 orphan no done", msg_done, 0);
    check("R6 note kept", note_led, 8'h01);
    check("R6 vel kept", velocity, 8'h02);
  endtask

  task automatic t_restart;
    send(8'h90);
    send(8'h10);
    send(8'h9F);
    check("R7 status no done", msg_done, 0);
    send(8'h7F);
    send(8'h00);
    check("R7 done", msg_done, 1);
    check("R7 note", note_led, 8'h7F);
    check("R7 vel", velocity, 8'h00);
  endtask

  task automatic t_no_valid;
    send(8'h92);
    @(negedge clk); rx_byte = 8'h55;
    @(negedge clk); rx_byte = 8'h66;
    @(negedge clk);
    check("R8 idle no done", msg_done, 0);
    send(8'h20);
    send(8'h30);
    check("R8 note", note_led, 8'h20);
    check("R8 vel", velocity, 8'h30);
  endtask

  task automatic t_hold;
    repeat (10) @(negedge clk);
    check("R9 note hold", note_led, 8'h20);
    check("R9 vel hold", velocity, 8'h30);
    check("R9 no done", msg_done, 0);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_note_on();
    t_note_off();
    t_other_cmd();
    t_orphan();
    t_restart();
    t_no_valid();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule